// File: doc/BRIEF.md
# Power Event Packet Accumulator

This block watches the processor bus and gathers power-management events into a small packet register. Each event source owns one bit of that register. A programmable address window feeds one bit. The window is a base value with a don't-care mask, and the bit is qualified separately by read and write cycles. A display-region strobe feeds a second bit, behind its own enable. A bit that has been set stays set until a packet carrying it has left the block. Repeats of the same event in the meantime are merged, and different events pile up in the same packet.

An interval timer paces the traffic. When the timer has run down and the packet holds at least one set bit, a serializer sends the 8-bit word on a clock/data pair, MSB first. At the end of that transmission the bits that were sent are cleared and the timer starts again from a programmable reload value. Software sets up the window, the enables and the reload value through a small synchronous register port. The register map is: index 0 is the window base, index 1 is the window mask with its cycle enables, index 2 is the event enable, and index 3 is the interval reload.

Top module: `pwr_evt_pkt_acc`

## Requirements
- R1: After reset, all four registers read zero, `ser_busy` is low, and both `ser_clk` and `ser_dat` are low.
- R2: The base register keeps only address bits 27..2 and reads zero elsewhere. The mask register keeps bits 27..2 plus its two enable bits 1..0, and reads zero in bits 31..28. The event enable register reads back bit 0 only.
- R3: For a window compare, each address bit in 27..2 whose mask bit is 0 must equal the base bit. A mask bit of 1 makes that position always match. Address bits 31..28 and 1..0 never affect the result.
- R4: Mask register bit 1 enables the compare on write strobes, and bit 0 enables it on read strobes. A strobe whose cycle type is not enabled never produces a window event.
- R5: A qualified window match sets packet bit 1. A display-region strobe sets packet bit 0 only while event enable bit 0 is 1.
- R6: A transmission starts only when the packet is nonzero and the interval timer has run down. While the timer is still counting, pending events wait.
- R7: A packet is 8 bits sent MSB first. Each bit takes two system cycles: `ser_clk` is low in the first and high in the second, and `ser_dat` is constant across both. `ser_busy` is high for exactly 16 cycles per packet.
- R8: A set packet bit stays set until the transmission that carried it completes, and it is cleared then. A bit set during a transmission that did not carry it survives into the next packet.
- R9: Repeats of an event between two transmissions produce no extra packet. Different events in the same interval are sent together in one packet.
- R10: An event arriving in the same cycle that a transmission completes is kept for the next packet.
- R11: The timer reloads from the interval register when each transmission completes. With events pending, `ser_busy` stays low for exactly reload+1 cycles between packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_idx | input | 2 | Register index (0 base, 1 mask, 2 enable, 3 reload) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_idx` |
| bus_addr | input | 32 | Address of the current bus cycle |
| bus_rd | input | 1 | Memory read strobe, one cycle per access |
| bus_wr | input | 1 | Memory write strobe, one cycle per access |
| bus_disp_hit | input | 1 | Display register or graphics memory access strobe |
| ser_clk | output | 1 | Serial packet clock |
| ser_dat | output | 1 | Serial packet data |
| ser_busy | output | 1 | High while a packet is being shifted |

## Verification
The checker assumes that the bus strobes and register writes are synchronous to `clk`. It also assumes `bus_addr` is valid whenever a strobe is high, and that an event source cannot clear packet bits. Only the end of a transmission may clear them. The bench drives every input from the falling edge and keeps each strobe for exactly one cycle. It changes the register contents only while the serializer is idle, so the packet, timer and shift timing seen by the properties always come from one consistent configuration.

// File: rtl/pea_pkg.sv
package pea_pkg;
   localparam int unsigned ADDR_W   = 32;
   localparam int unsigned FIELD_HI = 27;
   localparam int unsigned FIELD_LO = 2;
   localparam int unsigned IDX_W    = 2;

   typedef enum logic [IDX_W-1:0] {
      REG_BASE   = 2'd0,
      REG_MASK   = 2'd1,
      REG_ENABLE = 2'd2,
      REG_RELOAD = 2'd3
   } pea_reg_e;

   localparam int unsigned EVT_DISP = 0;
   localparam int unsigned EVT_WIN  = 1;

   function automatic logic [ADDR_W-1:0] field_bits(input int unsigned hi, input int unsigned lo);
      logic [ADDR_W-1:0] m;
      for (int i = 0; i < int'(ADDR_W); i++) m[i] = (i >= int'(lo)) && (i <= int'(hi));
      return m;
   endfunction
endpackage

// File: rtl/pea_regs.sv
module pea_regs
   import pea_pkg::*;
#(
   parameter int unsigned INTV_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic [ADDR_W-1:0] cfg_rdata,
   output logic [ADDR_W-1:0] win_base,
   output logic [ADDR_W-1:0] win_care,
   output logic              win_rd_en,
   output logic              win_wr_en,
   output logic              disp_en,
   output logic [INTV_W-1:0] reload
);
   localparam logic [ADDR_W-1:0] FIELD_M = field_bits(FIELD_HI, FIELD_LO);
   localparam logic [ADDR_W-1:0] MASK_M  = FIELD_M | ADDR_W'(3);

   generate
      if (INTV_W < 1 || INTV_W > ADDR_W) begin : g_bad_intv
         $error("pea_regs: INTV_W out of range");
      end
   endgenerate

   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] mask_q;
   logic              en_q;
   logic [INTV_W-1:0] reload_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         mask_q   <= '0;
         en_q     <= 1'b0;
         reload_q <= '0;
      end else if (cfg_wr) begin
         unique case (pea_reg_e'(cfg_idx))
            REG_BASE:   base_q   <= cfg_wdata & FIELD_M;
            REG_MASK:   mask_q   <= cfg_wdata & MASK_M;
            REG_ENABLE: en_q     <= cfg_wdata[0];
            REG_RELOAD: reload_q <= cfg_wdata[INTV_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      unique case (pea_reg_e'(cfg_idx))
         REG_BASE:   cfg_rdata = base_q;
         REG_MASK:   cfg_rdata = mask_q;
         REG_ENABLE: cfg_rdata = ADDR_W'(en_q);
         REG_RELOAD: cfg_rdata = ADDR_W'(reload_q);
         default:    cfg_rdata = '0;
      endcase
   end

   // positions that must compare: inside the field and not masked away
   assign win_base  = base_q;
   assign win_care  = FIELD_M & ~mask_q;
   assign win_wr_en = mask_q[1];
   assign win_rd_en = mask_q[0];
   assign disp_en   = en_q;
   assign reload    = reload_q;
endmodule

// File: rtl/pea_capture.sv
module pea_capture
   import pea_pkg::*;
#(
   parameter int unsigned PKT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic              bus_disp_hit,
   input  logic [ADDR_W-1:0] win_base,
   input  logic [ADDR_W-1:0] win_care,
   input  logic              win_rd_en,
   input  logic              win_wr_en,
   input  logic              disp_en,
   input  logic              tx_done,
   input  logic [PKT_W-1:0]  tx_sent,
   output logic [PKT_W-1:0]  pkt
);
   generate
      if (PKT_W < 2) begin : g_bad_pkt
         $error("pea_capture: PKT_W must hold both event bits");
      end
   endgenerate

   logic             addr_hit;
   logic             cyc_ok;
   logic [PKT_W-1:0] evt;
   logic [PKT_W-1:0] pkt_q;

   assign addr_hit = ((bus_addr ^ win_base) & win_care) == '0;
   assign cyc_ok   = (bus_rd & win_rd_en) | (bus_wr & win_wr_en);

   always_comb begin
      evt           = '0;
      evt[EVT_WIN]  = addr_hit & cyc_ok;
      evt[EVT_DISP] = bus_disp_hit & disp_en;
   end

   // one sticky bit per packet position; sent bits drop at completion,
   // a same-cycle event wins over the clear
   for (genvar b = 0; b < int'(PKT_W); b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pkt_q[b] <= 1'b0;
         else
            pkt_q[b] <= evt[b] | (pkt_q[b] & ~(tx_done & tx_sent[b]));
      end
   end

   assign pkt = pkt_q;
endmodule

// File: rtl/pea_interval.sv
module pea_interval #(
   parameter int unsigned INTV_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [INTV_W-1:0] reload,
   output logic              elapsed
);
   logic [INTV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart)
         cnt_q <= reload;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign elapsed = (cnt_q == '0);
endmodule

// File: rtl/pea_serializer.sv
module pea_serializer #(
   parameter int unsigned PKT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [PKT_W-1:0] data,
   output logic             busy,
   output logic             done,
   output logic [PKT_W-1:0] sent,
   output logic             ser_clk,
   output logic             ser_dat
);
   localparam int unsigned STEPS = 2 * PKT_W;
   localparam int unsigned CNT_W = $clog2(STEPS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

   logic             busy_q;
   logic [CNT_W-1:0] step_q;
   logic [PKT_W-1:0] shift_q;
   logic [PKT_W-1:0] snap_q;

   assign done = busy_q && (step_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         step_q  <= '0;
         shift_q <= '0;
         snap_q  <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q  <= 1'b1;
            step_q  <= '0;
            shift_q <= data;
            snap_q  <= data;
         end
      end else begin
         step_q <= step_q + 1'b1;
         if (step_q[0]) shift_q <= {shift_q[PKT_W-2:0], 1'b0};
         if (done) busy_q <= 1'b0;
      end
   end

   assign busy    = busy_q;
   assign sent    = snap_q;
   assign ser_clk = busy_q & step_q[0];
   assign ser_dat = busy_q & shift_q[PKT_W-1];
endmodule

// File: rtl/pwr_evt_pkt_acc.sv
module pwr_evt_pkt_acc
   import pea_pkg::*;
#(
   parameter int unsigned PKT_W  = 8,
   parameter int unsigned INTV_W = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_wr,
   input  logic [1:0]  cfg_idx,
   input  logic [31:0] cfg_wdata,
   output logic [31:0] cfg_rdata,
   input  logic [31:0] bus_addr,
   input  logic        bus_rd,
   input  logic        bus_wr,
   input  logic        bus_disp_hit,
   output logic        ser_clk,
   output logic        ser_dat,
   output logic        ser_busy
);
   logic [ADDR_W-1:0] win_base, win_care;
   logic              win_rd_en, win_wr_en, disp_en;
   logic [INTV_W-1:0] reload;
   logic [PKT_W-1:0]  pkt, sent;
   logic              tx_done, elapsed, start;

   pea_regs #(.INTV_W(INTV_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .win_base(win_base), .win_care(win_care),
      .win_rd_en(win_rd_en), .win_wr_en(win_wr_en),
      .disp_en(disp_en), .reload(reload)
   );

   pea_capture #(.PKT_W(PKT_W)) cap_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_disp_hit(bus_disp_hit),
      .win_base(win_base), .win_care(win_care),
      .win_rd_en(win_rd_en), .win_wr_en(win_wr_en), .disp_en(disp_en),
      .tx_done(tx_done), .tx_sent(sent), .pkt(pkt)
   );

   pea_interval #(.INTV_W(INTV_W)) tmr_i (
      .clk(clk), .rst_n(rst_n), .restart(tx_done), .reload(reload),
      .elapsed(elapsed)
   );

   assign start = !ser_busy && elapsed && (pkt != '0);

   pea_serializer #(.PKT_W(PKT_W)) ser_i (
      .clk(clk), .rst_n(rst_n), .start(start), .data(pkt),
      .busy(ser_busy), .done(tx_done), .sent(sent),
      .ser_clk(ser_clk), .ser_dat(ser_dat)
   );
endmodule

// File: rtl/pea_checker.sv
module pea_checker #(
   parameter int unsigned PKT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             done,
   input logic             elapsed,
   input logic [PKT_W-1:0] pkt,
   input logic             ser_clk,
   input logic             ser_dat
);
   localparam int unsigned LEN = 2 * PKT_W;
   localparam int unsigned LW  = $clog2(LEN) + 2;

   logic [LW-1:0] len_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    len_q <= '0;
      else if (busy) len_q <= len_q + 1'b1;
      else           len_q <= '0;
   end

   a_r7_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ser_clk && !ser_dat));

   a_r7_data_held: assert property (@(posedge clk) disable iff (!rst_n)
      ser_clk |-> $stable(ser_dat));

   a_r7_packet_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (len_q == LW'(LEN)));

   a_r6_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(elapsed) && ($past(pkt) != '0)));

   a_r8_clear_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(pkt) & ~pkt) != '0) |-> $past(done));
endmodule

bind pwr_evt_pkt_acc pea_checker #(.PKT_W(PKT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .busy(ser_busy), .done(tx_done),
   .elapsed(elapsed), .pkt(pkt), .ser_clk(ser_clk), .ser_dat(ser_dat)
);

// File: tb/pwr_evt_pkt_acc_tb_top.sv
module pwr_evt_pkt_acc_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [31:0] bus_addr = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_disp_hit = 1'b0;
   logic        ser_clk, ser_dat, ser_busy;

   int n_chk = 0;
   int n_fail = 0;
   bit done_flag = 1'b0;

   localparam logic [31:0] WIN_ADDR = 32'h0123_45A0;

   always #5 clk = ~clk;

   pwr_evt_pkt_acc dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_addr(bus_addr),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_disp_hit(bus_disp_hit),
      .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_busy(ser_busy)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] idx, input logic [31:0] val);
      @(negedge clk);
      cfg_idx = idx; cfg_wdata = val; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd_check(input logic [1:0] idx, input logic [31:0] exp, input string req);
      @(negedge clk);
      cfg_idx = idx;
      #1;
      check(cfg_rdata == exp, req, cfg_rdata, exp);
   endtask

   // one-cycle strobes driven at a falling edge: kind bit0 display, bit1 write, bit2 read
   task automatic strobe(input logic [2:0] kind, input logic [31:0] addr);
      @(negedge clk);
      bus_addr = addr; bus_disp_hit = kind[0]; bus_wr = kind[1]; bus_rd = kind[2];
      @(negedge clk);
      bus_disp_hit = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
   endtask

   // receives one packet; inj_bit selects the bit whose high phase gets an injected strobe
   task automatic get_pkt(output logic [7:0] val, output int len, input int inj_bit, input logic [2:0] inj_kind);
      int waited = 0;
      int nbit = 0;
      bit clk_lo_ok = 1'b1;
      val = '0; len = 0;
      while (!ser_busy && waited < 200) begin
         @(negedge clk); waited++;
      end
      while (ser_busy) begin
         bus_disp_hit = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
         len++;
         if (ser_clk) begin
            val = {val[6:0], ser_dat};
            if (nbit == inj_bit) begin
               bus_addr = WIN_ADDR; bus_disp_hit = inj_kind[0];
               bus_wr = inj_kind[1]; bus_rd = inj_kind[2];
            end
            nbit++;
         end else if ((len % 2) == 0) clk_lo_ok = 1'b0;
         @(negedge clk);
      end
      bus_disp_hit = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
      check(clk_lo_ok, "R7 clock phase order", 32'(clk_lo_ok), 32'd1);
   endtask

   task automatic expect_pkt(input logic [7:0] exp, input string req, input int inj_bit, input logic [2:0] inj_kind);
      logic [7:0] v; int l;
      get_pkt(v, l, inj_bit, inj_kind);
      check(v == exp, req, 32'(v), 32'(exp));
      check(l == 16, "R7 busy length", 32'(l), 32'd16);
   endtask

   task automatic expect_quiet(input int n, input string req);
      bit seen = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (ser_busy) seen = 1'b1;
      end
      check(!seen, req, 32'(seen), 32'd0);
   endtask

   task automatic t_reset();
      rd_check(2'd0, 32'h0, "R1 base reset");
      rd_check(2'd1, 32'h0, "R1 mask reset");
      rd_check(2'd2, 32'h0, "R1 enable reset");
      rd_check(2'd3, 32'h0, "R1 reload reset");
      check(!ser_busy && !ser_clk && !ser_dat, "R1 serial idle", {29'd0, ser_busy, ser_clk, ser_dat}, 32'd0);
   endtask

   task automatic t_regs();
      wr_reg(2'd0, 32'hFFFF_FFFF); rd_check(2'd0, 32'h0FFF_FFFC, "R2 base reserved");
      wr_reg(2'd1, 32'hFFFF_FFFF); rd_check(2'd1, 32'h0FFF_FFFF, "R2 mask reserved");
      wr_reg(2'd2, 32'hFFFF_FFFF); rd_check(2'd2, 32'h0000_0001, "R2 enable reserved");
      wr_reg(2'd0, 32'h0); wr_reg(2'd1, 32'h0); wr_reg(2'd2, 32'h0);
   endtask

   task automatic t_disp_gate();
      strobe(3'b001, 32'h0);
      expect_quiet(30, "R5 display strobe while disabled");
      wr_reg(2'd2, 32'h1);
      strobe(3'b001, 32'h0);
      expect_pkt(8'h01, "R5 display event bit0", -1, 3'b000);
   endtask

   task automatic t_window();
      wr_reg(2'd0, 32'h0123_4560);
      wr_reg(2'd1, 32'h0000_00F2);               // bits 7..4 don't care, write only
      strobe(3'b100, WIN_ADDR);
      expect_quiet(30, "R4 read not enabled");
      strobe(3'b010, 32'h0123_45A8);
      expect_quiet(30, "R3 cared bit 3 differs");
      strobe(3'b010, 32'h0123_4760);
      expect_quiet(30, "R3 cared bit 9 differs");
      strobe(3'b010, 32'hF123_45A3);
      expect_pkt(8'h02, "R3 R5 match ignoring outer bits", -1, 3'b000);
      wr_reg(2'd1, 32'h0000_00F1);               // read only
      strobe(3'b010, WIN_ADDR);
      expect_quiet(30, "R4 write not enabled");
      strobe(3'b100, WIN_ADDR);
      expect_pkt(8'h02, "R4 read match", -1, 3'b000);
      wr_reg(2'd1, 32'h0000_00F3);
   endtask

   task automatic t_sticky();
      strobe(3'b001, 32'h0);
      expect_pkt(8'h01, "R8 first packet", 3, 3'b001);
      expect_quiet(30, "R9 merged repeat during send");
      strobe(3'b001, 32'h0);
      expect_pkt(8'h01, "R8 resend", 3, 3'b010);
      expect_pkt(8'h02, "R8 unsent bit survives", -1, 3'b000);
   endtask

   task automatic t_done_edge();
      strobe(3'b001, 32'h0);
      expect_pkt(8'h01, "R10 packet before", 7, 3'b001);
      expect_pkt(8'h01, "R10 event at completion kept", -1, 3'b000);
   endtask

   task automatic t_interval();
      int gap = 0;
      wr_reg(2'd3, 32'd20);
      strobe(3'b001, 32'h0);
      expect_pkt(8'h01, "R11 packet before reload", 7, 3'b011);
      while (!ser_busy && gap < 200) begin
         @(negedge clk); gap++;
      end
      check(gap == 21, "R11 R6 gap equals reload+1", 32'(gap), 32'd21);
      expect_pkt(8'h03, "R9 two events accumulate", -1, 3'b000);
      strobe(3'b001, 32'h0);
      expect_quiet(15, "R6 waits for timer");
      expect_pkt(8'h01, "R6 sent after timer", -1, 3'b000);
      wr_reg(2'd3, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_disp_gate();
      t_window();
      t_sticky();
      t_done_edge();
      t_interval();
      done_flag = 1'b1;
   end

   initial begin
      fork
         wait (done_flag);
         begin
            repeat (100000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule